// File: doc/BRIEF.md
# Graphics Core Clock and Isolation Control Register

This block holds one 32-bit read/write word that sets how the graphics core's clocking is managed. Through it, software controls a core clock disable, a clock-scaling enable with a 7-bit factor giving how many clocks are kept, and a disable for memory clock gating. The same word reports whether the vector and 2D pipes are idle, and it always reports the absent 3D pipe as idle.

The word also drives two safety-critical outputs. One is a soft reset for the engines. The other is an isolate signal that cuts off the core's outbound bus master. Either one turns on only while every engine reports idle. A request made while an engine is busy is held until the engines go idle. When software releases the soft reset, the block opens a lockout window of 128 bus clock cycles. During that window every access is flagged on an error output, writes are dropped and reads return zero.

The bus side is a plain register port with select, write enable, address, write data and combinational read data. The register sits at one parameterised address. Other addresses read as zero and ignore writes.

Top module: `gfx_clk_ctrl`

## Requirements
- R1: After reset, with both idle inputs high, the register reads 0x00070900. softRst, isolate, ramGateDis, scaleEn and coreClkDis are 0, and scaleVal is 7'h40.
- R2: Bits 10 (ramGateDis), 9 (scaleEn), 8:2 (scaleVal, bit 2 is the LSB) and 1 (coreClkDis) are read/write. A write drives the matching output ports from the next clock edge.
- R3: Bit 16 (3D idle) and bit 11 always read 1. Bits 31:20, 15:13, 0 and 11 ignore writes, and every other unnamed bit reads 0.
- R4: Bit 18 reads the live idleVec input and bit 17 reads the live idle2d input. Writes to bits 18 and 17 have no effect.
- R5: Writing 1 to bit 19 (isolate) while both idle inputs are high sets isolate at that clock edge. If either pipe is busy, isolate stays 0 and the request is held. The isolate output then rises at the first clock edge at which both idle inputs are high. Writing 0 clears isolate and cancels a held request.
- R6: Bit 12 (softRst) follows the same idle-gated, held-request rules as isolate.
- R7: A write that changes softRst from 1 to 0 starts a lockout covering the 128 cycles after that edge. During the lockout, busErr is high for any access (busSel high) to any address, writes are discarded and busRdata is 0. After the lockout, busErr stays low.
- R8: Accesses to addresses other than REG_ADDR read 0 and do not change the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Access valid this cycle |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data |
| busErr | output | 1 | Access attempted during lockout |
| idleVec | input | 1 | Vector pipe idle |
| idle2d | input | 1 | 2D pipe idle |
| softRst | output | 1 | Soft reset to the engines |
| isolate | output | 1 | Blocks the outbound bus master |
| ramGateDis | output | 1 | Disables memory clock gating |
| scaleEn | output | 1 | Clock scaling enable |
| scaleVal | output | SCALE_W | Clocks kept per scaling window |
| coreClkDis | output | 1 | Core clock disable |

## Verification
Read data and busErr are combinational, so the bench samples them 1 ns after driving an access in the same cycle. Register outputs change at the write's clock edge, so the bench reads them at the following falling edge. A held isolate or soft-reset request completes at the first rising edge after the idle inputs go high, and the bench checks it one falling edge later. For the lockout, the bench counts falling edges after the releasing write. It expects busErr high at the 1st and 128th of them and low at the 129th.

// File: rtl/gfx_clk_ctrl_pkg.sv
package gfx_clk_ctrl_pkg;
  localparam int IsoBit    = 19;
  localparam int VIdleBit  = 18;
  localparam int Idle2dBit = 17;
  localparam int Idle3dBit = 16;
  localparam int SrstBit   = 12;
  localparam int RsvdOne   = 11;
  localparam int RamGBit   = 10;
  localparam int ScEnBit   = 9;
  localparam int ScLsb     = 2;
  localparam int ClkDisBit = 1;

  typedef struct packed {
    logic loadCfg;
    logic isoSet;
    logic isoClr;
    logic rstSet;
    logic rstClr;
  } ctrlStrb_t;
endpackage

// File: rtl/gfx_clk_ctrl_seq.sv
module gfx_clk_ctrl_seq
  import gfx_clk_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int REG_ADDR = 0,
  parameter int LOCK_CYC = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wIso,
  input  logic              wSrst,
  input  logic              allIdle,
  input  logic              srstQ,
  output ctrlStrb_t         strb,
  output logic              lockout,
  output logic              rdEn
);
  localparam int CntW = $clog2(LOCK_CYC + 1);
  localparam logic [CntW-1:0] CntLoad = CntW'(LOCK_CYC);

  logic [CntW-1:0] lockCnt;
  logic            isoPend, rstPend;
  logic            regHit, wrHit;

  assign regHit  = (busAddr == ADDR_W'(REG_ADDR));
  assign lockout = (lockCnt != '0);
  assign wrHit   = busSel & busWe & regHit & ~lockout;
  assign rdEn    = busSel & ~busWe & regHit & ~lockout;

  always_comb begin
    strb.loadCfg = wrHit;
    strb.isoClr  = wrHit & ~wIso;
    strb.isoSet  = allIdle & ((wrHit & wIso) | (isoPend & ~strb.isoClr));
    strb.rstClr  = wrHit & ~wSrst;
    strb.rstSet  = allIdle & ((wrHit & wSrst) | (rstPend & ~strb.rstClr));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isoPend <= 1'b0;
      rstPend <= 1'b0;
      lockCnt <= '0;
    end else begin
      if (strb.isoClr || allIdle)  isoPend <= 1'b0;
      else if (wrHit && wIso)      isoPend <= 1'b1;
      if (strb.rstClr || allIdle)  rstPend <= 1'b0;
      else if (wrHit && wSrst)     rstPend <= 1'b1;
      if (strb.rstClr && srstQ)    lockCnt <= CntLoad;
      else if (lockout)            lockCnt <= lockCnt - 1'b1;
    end
  end

  // R7: releasing soft reset opens the lockout window
  a_r7_lock_start: assert property (@(posedge clk) disable iff (!rstN)
    $fell(srstQ) |-> lockout);
  // R7: the window counter stays in range
  a_r7_cnt_range: assert property (@(posedge clk) disable iff (!rstN)
    lockCnt <= CntLoad);
  // R5: a held isolate request retires once the engines are idle
  a_r5_pend_retire: assert property (@(posedge clk) disable iff (!rstN)
    (isoPend && allIdle) |=> !isoPend);
  // R6: same for the soft reset request
  a_r6_pend_retire: assert property (@(posedge clk) disable iff (!rstN)
    (rstPend && allIdle) |=> !rstPend);
endmodule

// File: rtl/gfx_clk_ctrl_regs.sv
module gfx_clk_ctrl_regs
  import gfx_clk_ctrl_pkg::*;
#(
  parameter int SCALE_W = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrb_t          strb,
  input  logic [31:0]        wdata,
  input  logic               idleVec,
  input  logic               idle2d,
  input  logic               rdEn,
  output logic [31:0]        rdata,
  output logic               isoQ,
  output logic               srstQ,
  output logic               ramGateDis,
  output logic               scaleEn,
  output logic [SCALE_W-1:0] scaleVal,
  output logic               coreClkDis
);
  localparam logic [SCALE_W-1:0] ScaleRst = SCALE_W'(1) << (SCALE_W - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isoQ       <= 1'b0;
      srstQ      <= 1'b0;
      ramGateDis <= 1'b0;
      scaleEn    <= 1'b0;
      scaleVal   <= ScaleRst;
      coreClkDis <= 1'b0;
    end else begin
      if (strb.isoClr)      isoQ <= 1'b0;
      else if (strb.isoSet) isoQ <= 1'b1;
      if (strb.rstClr)      srstQ <= 1'b0;
      else if (strb.rstSet) srstQ <= 1'b1;
      if (strb.loadCfg) begin
        ramGateDis <= wdata[RamGBit];
        scaleEn    <= wdata[ScEnBit];
        scaleVal   <= wdata[ScLsb +: SCALE_W];
        coreClkDis <= wdata[ClkDisBit];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (rdEn) begin
      rdata[IsoBit]              = isoQ;
      rdata[VIdleBit]            = idleVec;
      rdata[Idle2dBit]           = idle2d;
      rdata[Idle3dBit]           = 1'b1;
      rdata[SrstBit]             = srstQ;
      rdata[RsvdOne]             = 1'b1;
      rdata[RamGBit]             = ramGateDis;
      rdata[ScEnBit]             = scaleEn;
      rdata[ScLsb +: SCALE_W]    = scaleVal;
      rdata[ClkDisBit]           = coreClkDis;
    end
  end

  // R5: isolate only rises after a cycle where all engines were idle
  a_r5_iso_idle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(isoQ) |-> $past(idleVec && idle2d));
  // R6: soft reset only rises after a cycle where all engines were idle
  a_r6_srst_idle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(srstQ) |-> $past(idleVec && idle2d));
  // R2: configuration fields move only on an accepted write
  a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.loadCfg) |-> $stable({ramGateDis, scaleEn, scaleVal, coreClkDis}));
  // R3: fixed bits on every read
  a_r3_fixed_bits: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> (rdata[Idle3dBit] && rdata[RsvdOne] && rdata[31:20] == '0 && rdata[0] == 1'b0));
endmodule

// File: rtl/gfx_clk_ctrl.sv
module gfx_clk_ctrl
  import gfx_clk_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int REG_ADDR = 0,
  parameter int LOCK_CYC = 128,
  parameter int SCALE_W  = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  output logic               busErr,
  input  logic               idleVec,
  input  logic               idle2d,
  output logic               softRst,
  output logic               isolate,
  output logic               ramGateDis,
  output logic               scaleEn,
  output logic [SCALE_W-1:0] scaleVal,
  output logic               coreClkDis
);
  ctrlStrb_t strb;
  logic      lockout, rdEn, srstQ, isoQ;

  gfx_clk_ctrl_seq #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .LOCK_CYC(LOCK_CYC)) uSeq (
    .clk, .rstN, .busSel, .busWe, .busAddr,
    .wIso(busWdata[IsoBit]), .wSrst(busWdata[SrstBit]),
    .allIdle(idleVec & idle2d), .srstQ,
    .strb, .lockout, .rdEn
  );

  gfx_clk_ctrl_regs #(.SCALE_W(SCALE_W)) uRegs (
    .clk, .rstN, .strb, .wdata(busWdata), .idleVec, .idle2d, .rdEn,
    .rdata(busRdata), .isoQ, .srstQ,
    .ramGateDis, .scaleEn, .scaleVal, .coreClkDis
  );

  assign busErr  = busSel & lockout;
  assign softRst = srstQ;
  assign isolate = isoQ;
endmodule

// File: tb/tb_gfx_clk_ctrl.sv
module tb_gfx_clk_ctrl;
  logic clk = 1'b0, rstN = 1'b0;
  logic busSel = 0, busWe = 0;
  logic [3:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic busErr, idleVec = 1, idle2d = 1;
  logic softRst, isolate, ramGateDis, scaleEn, coreClkDis;
  logic [6:0] scaleVal;
  int nVec = 0, nBad = 0;
  bit finished = 0;
  logic [31:0] rd;
  logic er;

  always #2 clk = ~clk;

  gfx_clk_ctrl dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // entered and left at a falling edge; rd/er captured 1 ns into the cycle
  task automatic acc(input logic we, input logic [3:0] a, input logic [31:0] d);
    busSel = 1; busWe = we; busAddr = a; busWdata = d;
    #1 rd = busRdata; er = busErr;
    @(negedge clk);
    busSel = 0; busWe = 0;
  endtask

  function automatic logic [31:0] expRd(input logic [9:0] cfg, input logic iso, input logic sr);
    return 32'h0001_0800 | (32'(iso) << 19) | (32'(idleVec) << 18) | (32'(idle2d) << 17)
         | (32'(sr) << 12) | (32'(cfg) << 1);
  endfunction

  function automatic logic [31:0] outs();
    return {20'h0, isolate, softRst, ramGateDis, scaleEn, scaleVal, coreClkDis};
  endfunction

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nVec++; nBad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    logic [9:0] cfg;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset value and outputs
    acc(0, 0, 0);
    chk("R1 read", rd, 32'h0007_0900);
    chk("R1 outs", outs(), {20'h0, 2'b00, 2'b00, 7'h40, 1'b0});

    // R2/R3/R4 sweep of configuration fields, junk in ignored bits
    for (int s = 0; s < 128; s++) begin
      for (int m = 0; m < 8; m++) begin
        cfg = {m[2], m[1], s[6:0], m[0]};
        acc(1, 0, 32'hFFF6_E801 | (32'(cfg) << 1));
        acc(0, 0, 0);
        chk("R2/R3/R4 readback", rd, expRd(cfg, 0, 0));
        chk("R2 ports", outs(), {20'h0, 2'b00, cfg});
      end
    end

    // R4 live idle readback
    for (int k = 0; k < 4; k++) begin
      idleVec = k[0]; idle2d = k[1];
      acc(0, 0, 0);
      chk("R4 live idle", rd, expRd(cfg, 0, 0));
    end
    idleVec = 1; idle2d = 1;

    // R8 other addresses
    for (int a = 1; a < 16; a++) begin
      acc(1, a[3:0], 32'h0000_0002);
      chk("R8 read other", {31'h0, er}, 0);
      acc(0, a[3:0], 0);
      chk("R8 read other", rd, 0);
    end
    acc(0, 0, 0);
    chk("R8 no change", rd, expRd(cfg, 0, 0));

    // R5 isolate: busy then idle
    idle2d = 0;
    acc(1, 0, 32'h0008_0000 | (32'(cfg) << 1));
    chk("R5 held iso", {31'h0, isolate}, 0);
    repeat (3) @(negedge clk);
    chk("R5 still held", {31'h0, isolate}, 0);
    idle2d = 1;
    @(negedge clk);
    chk("R5 iso on idle", {31'h0, isolate}, 1);
    acc(1, 0, 32'(cfg) << 1);
    chk("R5 iso clear", {31'h0, isolate}, 0);
    // R5 cancel held request
    idleVec = 0;
    acc(1, 0, 32'h0008_0000 | (32'(cfg) << 1));
    acc(1, 0, 32'(cfg) << 1);
    idleVec = 1;
    repeat (2) @(negedge clk);
    chk("R5 cancel", {31'h0, isolate}, 0);
    // R5 immediate when idle
    acc(1, 0, 32'h0008_0000 | (32'(cfg) << 1));
    chk("R5 iso immediate", {31'h0, isolate}, 1);
    acc(1, 0, 32'(cfg) << 1);

    // R6 soft reset held then released
    idleVec = 0;
    acc(1, 0, 32'h0000_1000 | (32'(cfg) << 1));
    chk("R6 held srst", {31'h0, softRst}, 0);
    idleVec = 1;
    @(negedge clk);
    chk("R6 srst on idle", {31'h0, softRst}, 1);
    acc(0, 0, 0);
    chk("R6 readback", rd, expRd(cfg, 0, 1));

    // R7 lockout after release
    acc(1, 0, 32'(cfg) << 1);
    chk("R7 srst off", {31'h0, softRst}, 0);
    acc(1, 0, 32'h0000_07FE);          // cycle 1: discarded
    chk("R7 err first", {31'h0, er}, 1);
    acc(0, 5, 0);                       // cycle 2
    chk("R7 err other addr", {31'h0, er}, 1);
    repeat (125) @(negedge clk);        // now cycle 128
    acc(0, 0, 0);
    chk("R7 err last", {31'h0, er}, 1);
    chk("R7 rdata zero", rd, 0);
    acc(0, 0, 0);                       // cycle 129
    chk("R7 err gone", {31'h0, er}, 0);
    chk("R7 write dropped", rd, expRd(cfg, 0, 0));

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule